// File: doc/BRIEF.md
# Configuration Readback CRC Scrubber

This block keeps watch over a device's configuration memory without any help from outside. It works through a fixed list of frame addresses in order. For each address it sends a fixed sequence of command words to a word-wide readback port. It then takes in the frame's data words and folds each accepted word into a running 32-bit CRC. When the last frame of the list is done, the pass is complete.

The first complete pass after reset stores its CRC as the golden signature. Every later pass compares its own CRC with that signature. Any difference raises a fault flag, which stays set until the next reset. A one-cycle pulse marks the end of each pass. The next pass begins at once with the first frame, so checking never stops.

The frame list and the command buffer are built at elaboration from parameters. The readback port is a plain request/data pair: the block holds a request high while it reads a frame and accepts a word on each cycle in which the valid input is high.

Top module: `cfg_crc_scrubber`

## Requirements
- R1: While reset is asserted and at the first sample after it, `pass_done`, `golden_valid`, `config_fail`, `rb_cmd_valid` and `rb_rd_req` are all 0.
- R2: For each frame, `rb_cmd_valid` is high for CMD_WORDS consecutive cycles. Command word k equals 32'h3000_0000 | k, except word ADDR_SLOT (default 3), which carries the frame address. Frame i has address FRAME_BASE + i*FRAME_STRIDE, and frames are visited in ascending i.
- R3: After its commands, a frame is read with `rb_rd_req` held high until WORDS_PER_FRAME words have been accepted. Cycles with `rb_rd_valid` low are ignored and do not change the checksum.
- R4: The pass checksum is a CRC with polynomial 0x04C11DB7 and an all-ones start value, with no final inversion. Each 32-bit word is processed MSB first, and the words are taken in frame order, then word order.
- R5: The first pass after reset stores its CRC on `ref_sig` and sets `golden_valid`. `ref_sig` then stays unchanged until reset, and that first pass never sets `config_fail`.
- R6: A later pass whose CRC differs from `ref_sig` sets `config_fail`. It stays set, through later matching passes, until reset. A matching pass leaves it unchanged.
- R7: `pass_done` is a one-cycle pulse at the end of every pass, and the following pass restarts at frame 0.
- R8: With NUM_FRAMES = 0, every pass completes at once with CRC 32'hFFFF_FFFF and no readback traffic. `pass_done` pulses every second cycle.
- R9: `rb_cmd_valid` and `rb_rd_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_cmd_valid | output | 1 | Command word present on `rb_cmd_data` |
| rb_cmd_data | output | 32 | Readback command word |
| rb_rd_req | output | 1 | Frame data requested |
| rb_rd_valid | input | 1 | Readback data word valid this cycle |
| rb_rd_data | input | 32 | Readback data word |
| pass_done | output | 1 | One-cycle end-of-pass pulse |
| golden_valid | output | 1 | Golden signature captured |
| config_fail | output | 1 | Sticky signature mismatch |
| ref_sig | output | 32 | Captured golden signature |

## Verification
Passes are run with the data valid every cycle, every second cycle, and two cycles out of three. Identical data under different stall patterns must give the same signature, which separates accepted words from stalled cycles. A single flipped bit in one word of frame 1 must raise the fault flag. A clean pass after that must leave the flag set. A reset part-way through a pass, followed by a golden pass with a different bit flipped, shows that the signature is captured again and that the flag clears. A second instance with no frames covers the empty-list case.

// File: rtl/cfg_scrub_pkg.sv
package cfg_scrub_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND_CMD,
      ST_READ_FRAME,
      ST_NEXT_FRAME,
      ST_COMPARE
   } scrub_state_t;

   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
   localparam logic [31:0] CMD_BASE = 32'h3000_0000;

   // One full 32-bit word folded into the CRC, MSB first.
   function automatic logic [31:0] crc32_word(input logic [31:0] crc_in,
                                              input logic [31:0] data);
      logic [31:0] c;
      logic        fb;
      c = crc_in;
      for (int b = 31; b >= 0; b--) begin
         fb = c[31] ^ data[b];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ CRC_POLY;
      end
      return c;
   endfunction

endpackage

// File: rtl/crc32_word_acc.sv
module crc32_word_acc
   import cfg_scrub_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        en,
   input  logic [31:0] data,
   output logic [31:0] crc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= CRC_SEED;
      else if (clear) crc <= CRC_SEED;
      else if (en)    crc <= crc32_word(crc, data);
   end

endmodule

// File: rtl/frame_addr_rom.sv
module frame_addr_rom #(
   parameter int          NUM_FRAMES   = 4,
   parameter int          IDX_W        = 2,
   parameter logic [31:0] FRAME_BASE   = 32'h0040_0000,
   parameter logic [31:0] FRAME_STRIDE = 32'h0000_0100
) (
   input  logic [IDX_W-1:0] idx,
   output logic [31:0]      addr
);

   generate
      if (NUM_FRAMES == 0) begin : g_empty
         assign addr = FRAME_BASE;
         logic unused_idx;
         assign unused_idx = ^idx;
      end else begin : g_table
         logic [31:0] tbl [NUM_FRAMES];
         for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_ent
            assign tbl[i] = FRAME_BASE + FRAME_STRIDE * 32'(i);
         end
         always_comb begin
            addr = FRAME_BASE;
            for (int i = 0; i < NUM_FRAMES; i++)
               if (idx == IDX_W'(i)) addr = tbl[i];
         end
      end
   endgenerate

endmodule

// File: rtl/cmd_buffer.sv
module cmd_buffer
   import cfg_scrub_pkg::*;
#(
   parameter int CMD_WORDS = 11,
   parameter int IDX_W     = 4,
   parameter int ADDR_SLOT = 3
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      frame_addr,
   output logic [31:0]      word
);

   logic [31:0] tbl [CMD_WORDS];

   generate
      for (genvar k = 0; k < CMD_WORDS; k++) begin : g_word
         if (k == ADDR_SLOT) begin : g_addr
            assign tbl[k] = frame_addr;
         end else begin : g_fixed
            assign tbl[k] = CMD_BASE | 32'(k);
         end
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int k = 0; k < CMD_WORDS; k++)
         if (idx == IDX_W'(k)) word = tbl[k];
   end

endmodule

// File: rtl/cfg_crc_scrubber.sv
module cfg_crc_scrubber
   import cfg_scrub_pkg::*;
#(
   parameter int          NUM_FRAMES      = 4,
   parameter int          WORDS_PER_FRAME = 4,
   parameter int          CMD_WORDS       = 11,
   parameter int          ADDR_SLOT       = 3,
   parameter logic [31:0] FRAME_BASE      = 32'h0040_0000,
   parameter logic [31:0] FRAME_STRIDE    = 32'h0000_0100
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        rb_cmd_valid,
   output logic [31:0] rb_cmd_data,
   output logic        rb_rd_req,
   input  logic        rb_rd_valid,
   input  logic [31:0] rb_rd_data,
   output logic        pass_done,
   output logic        golden_valid,
   output logic        config_fail,
   output logic [31:0] ref_sig
);

   localparam int FRM_W = (NUM_FRAMES > 1)      ? $clog2(NUM_FRAMES)      : 1;
   localparam int CMD_W = (CMD_WORDS > 1)       ? $clog2(CMD_WORDS)       : 1;
   localparam int WRD_W = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1;
   localparam bit EMPTY = (NUM_FRAMES == 0);
   localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'((NUM_FRAMES > 0) ? NUM_FRAMES - 1 : 0);
   localparam logic [CMD_W-1:0] CMD_LAST = CMD_W'(CMD_WORDS - 1);
   localparam logic [WRD_W-1:0] WRD_LAST = WRD_W'(WORDS_PER_FRAME - 1);

   generate
      if (NUM_FRAMES < 0)        begin : g_bad_frames $error("NUM_FRAMES must be >= 0");        end
      if (WORDS_PER_FRAME < 1)   begin : g_bad_words  $error("WORDS_PER_FRAME must be >= 1");   end
      if (CMD_WORDS < 1)         begin : g_bad_cmds   $error("CMD_WORDS must be >= 1");         end
      if (ADDR_SLOT >= CMD_WORDS) begin : g_bad_slot  $error("ADDR_SLOT must be < CMD_WORDS");  end
   endgenerate

   scrub_state_t      state, state_nxt;
   logic [FRM_W-1:0]  frm_idx;
   logic [CMD_W-1:0]  cmd_idx;
   logic [WRD_W-1:0]  wrd_idx;
   logic [31:0]       frame_addr;
   logic [31:0]       crc;
   logic              crc_en;
   logic              crc_clear;

   frame_addr_rom #(
      .NUM_FRAMES  (NUM_FRAMES),
      .IDX_W       (FRM_W),
      .FRAME_BASE  (FRAME_BASE),
      .FRAME_STRIDE(FRAME_STRIDE)
   ) u_rom (
      .idx (frm_idx),
      .addr(frame_addr)
   );

   cmd_buffer #(
      .CMD_WORDS(CMD_WORDS),
      .IDX_W    (CMD_W),
      .ADDR_SLOT(ADDR_SLOT)
   ) u_cmd (
      .idx       (cmd_idx),
      .frame_addr(frame_addr),
      .word      (rb_cmd_data)
   );

   crc32_word_acc u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(crc_clear),
      .en   (crc_en),
      .data (rb_rd_data),
      .crc  (crc)
   );

   assign rb_cmd_valid = (state == ST_SEND_CMD);
   assign rb_rd_req    = (state == ST_READ_FRAME);
   assign crc_en       = rb_rd_req && rb_rd_valid;
   assign crc_clear    = (state == ST_COMPARE);

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:       state_nxt = EMPTY ? ST_COMPARE : ST_SEND_CMD;
         ST_SEND_CMD:   if (cmd_idx == CMD_LAST) state_nxt = ST_READ_FRAME;
         ST_READ_FRAME: if (rb_rd_valid && wrd_idx == WRD_LAST) state_nxt = ST_NEXT_FRAME;
         ST_NEXT_FRAME: state_nxt = (frm_idx == FRM_LAST) ? ST_COMPARE : ST_SEND_CMD;
         ST_COMPARE:    state_nxt = EMPTY ? ST_IDLE : ST_SEND_CMD;
         default:       state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         frm_idx <= '0;
         cmd_idx <= '0;
         wrd_idx <= '0;
      end else begin
         state <= state_nxt;
         if (state == ST_SEND_CMD)
            cmd_idx <= (cmd_idx == CMD_LAST) ? '0 : cmd_idx + 1'b1;
         if (crc_en)
            wrd_idx <= (wrd_idx == WRD_LAST) ? '0 : wrd_idx + 1'b1;
         if (state == ST_NEXT_FRAME)
            frm_idx <= (frm_idx == FRM_LAST) ? '0 : frm_idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_done    <= 1'b0;
         golden_valid <= 1'b0;
         config_fail  <= 1'b0;
         ref_sig      <= '0;
      end else begin
         pass_done <= (state == ST_COMPARE);
         if (state == ST_COMPARE) begin
            if (!golden_valid) begin
               ref_sig      <= crc;
               golden_valid <= 1'b1;
            end else if (crc != ref_sig) begin
               config_fail  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cfg_crc_scrubber_chk.sv
module cfg_crc_scrubber_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rb_cmd_valid,
   input logic        rb_rd_req,
   input logic        rb_rd_valid,
   input logic        pass_done,
   input logic        golden_valid,
   input logic        config_fail,
   input logic [31:0] ref_sig
);

   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rb_cmd_valid && rb_rd_req));

   assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      config_fail |=> config_fail);

   assert_fail_after_golden_R6: assert property (@(posedge clk) disable iff (!rst_n)
      config_fail |-> golden_valid);

   assert_golden_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      golden_valid |=> (golden_valid && $stable(ref_sig)));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);

   assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_rd_req && !rb_rd_valid) |=> rb_rd_req);

endmodule

bind cfg_crc_scrubber cfg_crc_scrubber_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rb_cmd_valid(rb_cmd_valid),
   .rb_rd_req   (rb_rd_req),
   .rb_rd_valid (rb_rd_valid),
   .pass_done   (pass_done),
   .golden_valid(golden_valid),
   .config_fail (config_fail),
   .ref_sig     (ref_sig)
);

// File: tb/cfg_crc_scrubber_test.sv
module cfg_crc_scrubber_test;

   localparam int          NF     = 4;
   localparam int          NW     = 4;
   localparam int          NC     = 11;
   localparam int          SLOT   = 3;
   localparam logic [31:0] BASE   = 32'h0040_0000;
   localparam logic [31:0] STRIDE = 32'h0000_0100;

   // {gap mode, flip mask, expected config_fail}
   localparam int NV = 5;
   localparam logic [34:0] VEC [NV] = '{
      {2'd0, 32'h0000_0000, 1'b0},
      {2'd1, 32'h0000_0000, 1'b0},
      {2'd2, 32'h0000_0000, 1'b0},
      {2'd0, 32'h0000_0001, 1'b1},
      {2'd1, 32'h0000_0000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rb_cmd_valid, rb_rd_req, pass_done, golden_valid, config_fail;
   logic [31:0] rb_cmd_data, ref_sig;
   logic        rb_rd_valid = 1'b0;
   logic [31:0] rb_rd_data = '0;

   logic        e_cmd_valid, e_rd_req, e_pass_done, e_golden_valid, e_config_fail;
   logic [31:0] e_cmd_data, e_ref_sig;

   int          checks = 0;
   int          errors = 0;
   logic [1:0]  gap = 2'd0;
   logic [31:0] cur_flip = '0;
   int          cyc = 0;
   int          cidx = 0, fidx = 0, cap_frame = 0, wcnt = 0;
   logic [31:0] cap_addr = '0;

   always #5 clk = ~clk;

   cfg_crc_scrubber #(.NUM_FRAMES(NF), .WORDS_PER_FRAME(NW), .CMD_WORDS(NC),
                      .ADDR_SLOT(SLOT), .FRAME_BASE(BASE), .FRAME_STRIDE(STRIDE)) uut (
      .clk(clk), .rst_n(rst_n), .rb_cmd_valid(rb_cmd_valid), .rb_cmd_data(rb_cmd_data),
      .rb_rd_req(rb_rd_req), .rb_rd_valid(rb_rd_valid), .rb_rd_data(rb_rd_data),
      .pass_done(pass_done), .golden_valid(golden_valid), .config_fail(config_fail),
      .ref_sig(ref_sig));

   cfg_crc_scrubber #(.NUM_FRAMES(0), .WORDS_PER_FRAME(NW), .CMD_WORDS(NC),
                      .ADDR_SLOT(SLOT), .FRAME_BASE(BASE), .FRAME_STRIDE(STRIDE)) uut_empty (
      .clk(clk), .rst_n(rst_n), .rb_cmd_valid(e_cmd_valid), .rb_cmd_data(e_cmd_data),
      .rb_rd_req(e_rd_req), .rb_rd_valid(1'b0), .rb_rd_data(32'h0),
      .pass_done(e_pass_done), .golden_valid(e_golden_valid), .config_fail(e_config_fail),
      .ref_sig(e_ref_sig));

   function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [31:0] d);
      logic [31:0] c = c0;
      for (int b = 31; b >= 0; b--) begin
         logic top = c[31] ^ d[b];
         c = c << 1;
         if (top) c = c ^ 32'h04C1_1DB7;
      end
      return c;
   endfunction

   function automatic logic [31:0] model_word(input logic [31:0] a, input int w);
      return {a[15:0], 8'h00, 8'(w)} ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] pass_crc(input logic [31:0] flip);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int f = 0; f < NF; f++)
         for (int w = 0; w < NW; w++)
            c = ref_crc(c, model_word(BASE + STRIDE * 32'(f), w) ^ ((f == 1 && w == 0) ? flip : 32'h0));
      return c;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Readback port model and command monitor
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         cidx = 0; fidx = 0; wcnt = 0; rb_rd_valid <= 1'b0;
      end else begin
         if (pass_done) begin cidx = 0; fidx = 0; end
         if (e_cmd_valid || e_rd_req) check("R8 empty list traffic", 32'(e_cmd_valid), 32'h0);
         if (rb_cmd_valid) begin
            check("R2 command word", rb_cmd_data,
                  (cidx == SLOT) ? BASE + STRIDE * 32'(fidx) : (32'h3000_0000 | 32'(cidx)));
            if (cidx == SLOT) begin cap_addr = rb_cmd_data; cap_frame = fidx; end
            wcnt = 0;
            cidx++;
            if (cidx == NC) begin cidx = 0; fidx++; end
         end
         if (rb_rd_req && (gap == 2'd0 || (gap == 2'd1 && cyc % 2 == 0) ||
                           (gap == 2'd2 && cyc % 3 != 0))) begin
            rb_rd_valid <= 1'b1;
            rb_rd_data  <= model_word(cap_addr, wcnt) ^ ((cap_frame == 1 && wcnt == 0) ? cur_flip : 32'h0);
            wcnt++;
         end else begin
            rb_rd_valid <= 1'b0;
            rb_rd_data  <= 32'hDEAD_BEEF;
         end
      end
   end

   task automatic wait_pass();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!pass_done && n < 3000);
      if (!pass_done) begin
         errors++;
         $display("FAIL R7 watchdog actual=no pass_done expected=pass_done");
      end
   endtask

   logic [31:0] golden;

   initial begin
      gap      = VEC[0][34:33];
      cur_flip = VEC[0][32:1];
      repeat (2) @(negedge clk);
      check("R1 reset pass_done", 32'(pass_done), 0);
      check("R1 reset golden_valid", 32'(golden_valid), 0);
      check("R1 reset config_fail", 32'(config_fail), 0);
      check("R1 reset cmd/rd", {30'h0, rb_cmd_valid, rb_rd_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first sample", {28'h0, pass_done, golden_valid, config_fail, rb_rd_req}, 0);

      golden = pass_crc(32'h0);
      for (int i = 0; i < NV; i++) begin
         wait_pass();
         if (i + 1 < NV) begin
            gap      = VEC[i+1][34:33];
            cur_flip = VEC[i+1][32:1];
         end
         check("R5 golden_valid", 32'(golden_valid), 1);
         check("R4 R5 ref_sig", ref_sig, golden);
         check("R6 config_fail", 32'(config_fail), 32'(VEC[i][0]));
         @(negedge clk);
         check("R7 pulse width", 32'(pass_done), 0);
      end

      // R8: empty frame list
      check("R8 empty ref_sig", e_ref_sig, 32'hFFFF_FFFF);
      check("R8 empty golden_valid", 32'(e_golden_valid), 1);
      check("R8 empty config_fail", 32'(e_config_fail), 0);
      begin
         int pulses = 0;
         for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (e_pass_done) pulses++;
         end
         check("R8 empty pulse rate", 32'(pulses), 5);
      end

      // Reset mid-pass, recapture golden with a flipped bit
      repeat (20) @(negedge clk);
      gap = 2'd0;
      cur_flip = 32'h8000_0000;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 R6 fail cleared by reset", 32'(config_fail), 0);
      check("R1 golden cleared by reset", 32'(golden_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_pass();
      cur_flip = 32'h0;
      check("R5 recaptured ref_sig", ref_sig, pass_crc(32'h8000_0000));
      check("R5 no fail on golden pass", 32'(config_fail), 0);
      wait_pass();
      check("R6 mismatch after recapture", 32'(config_fail), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_900_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule